// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds a set of byte-wide configuration registers. Each register has two copies: a shadow copy that serial writes land in, and a live copy that drives the rest of the chip. The serial interface writes only the shadow copies. The shadow copies move into the live copies together only when software writes the commit register. Downstream logic therefore sees a whole group of settings change on a single clock edge, never a half-written group.

Two locations bypass the double buffering. These are the serial-port configuration byte and the byte that holds the readback-source bit. A write to either one takes effect on the next clock edge.

A read returns one byte, one clock edge after the read address is presented. The readback-source bit decides whether that byte comes from the shadow copy or from the live copy. The commit register is the last address of the map. It clears itself once the commit has happened.

Top module: `dbr_bank`

## Requirements
- R1: After reset, the shadow and live copies of every location hold the same default. The default is 0x18 at address 0x000 and 0x00 at every other location. The commit register at 0x232 reads 0.
- R2: A write to a buffered address changes that location's shadow copy. Its live output stays unchanged until a commit.
- R3: A write to address 0x232 with data bit 0 equal to 1 starts a commit. On the following clock edge, every buffered location's live copy takes its shadow value.
- R4: A write to 0x232 with data bit 0 equal to 0 starts no commit, and the live outputs keep their values.
- R5: The commit flag at 0x232 clears itself on the edge that performs the transfer. A later readback of 0x232 returns 0x00.
- R6: Addresses 0x000 and 0x004 are direct. A write to either one updates both copies, and the live output, on the edge that captures the write. No commit is needed.
- R7: Bit 0 of the byte at 0x004 picks the readback source: 0 returns the shadow copy and 1 returns the live copy. The read data is registered and shows the addressed byte one edge after the read address is presented.
- R8: A buffered write captured on the same edge as the commit transfer is part of that transfer. Its value reaches the live copy on that edge.
- R9: Writes to addresses above 0x232 are ignored. Reads of those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W (10) | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W (10) | Read address |
| rd_data | output | 8 | Registered read data |
| live_regs | output | NUM_REGS*8 (4504) | Live copies, byte n at bits [8n+7:8n] |

## Verification
The assertions assume that the write strobe, address and data are stable around the clock edge. They also assume that no other source touches the live copies, so a live byte may change only through a commit or through a direct write. The bench drives every input on the falling edge, one write per strobe cycle. It places the buffered write for the merge case on the strobe cycle right after the commit write, the only cycle where a write and a transfer share an edge. Out-of-range addresses are tested only with reads and ignored writes, so the checker's stability property on the lower buffered bytes is never disturbed by a legal commit it does not expect.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t shadow;
        byte_t live;
    } cell_st;

    typedef struct packed {
        logic pend;
    } commit_st;

    typedef struct packed {
        byte_t data;
    } rd_st;
endpackage

// File: rtl/dbr_cell.sv
module dbr_cell
    import dbr_pkg::*;
#(
    parameter bit    DIRECT  = 1'b0,
    parameter byte_t RST_VAL = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  xfer,
    output byte_t shadow_q,
    output byte_t live_q
);
    cell_st st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.shadow = wr_data;
        end
        if (DIRECT) begin
            if (wr_en) begin
                st_d.live = wr_data;
            end
        end else if (xfer) begin
            st_d.live = st_d.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shadow <= RST_VAL;
            st_q.live   <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_q = st_q.shadow;
    assign live_q   = st_q.live;
endmodule

// File: rtl/dbr_commit.sv
module dbr_commit
    import dbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic go_bit,
    output logic pend_q
);
    commit_st st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = hit && go_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
endmodule

// File: rtl/dbr_rdmux.sv
module dbr_rdmux
    import dbr_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 563
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic                       use_live,
    input  logic [NUM_REGS*BYTE_W-1:0] shd_flat,
    input  logic [NUM_REGS*BYTE_W-1:0] live_flat,
    output byte_t                      rd_data
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

    rd_st st_d, st_q;
    logic [ADDR_W+2:0] bit_idx;

    always_comb begin
        bit_idx = {rd_addr, 3'b000};
        st_d    = st_q;
        if (rd_addr > LAST) begin
            st_d.data = '0;
        end else if (use_live) begin
            st_d.data = live_flat[bit_idx +: BYTE_W];
        end else begin
            st_d.data = shd_flat[bit_idx +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;
endmodule

// File: rtl/dbr_bank.sv
module dbr_bank
    import dbr_pkg::*;
#(
    parameter int    ADDR_W     = 10,
    parameter int    NUM_REGS   = 563,
    parameter int    CFG_ADDR   = 0,
    parameter int    SEL_ADDR   = 4,
    parameter byte_t CFG_RST    = 8'h18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data,
    output logic [NUM_REGS*8-1:0]      live_regs
);
    localparam int                COMMIT_IDX  = NUM_REGS - 1;
    localparam logic [ADDR_W-1:0] COMMIT_ADDR = ADDR_W'(COMMIT_IDX);

    logic [NUM_REGS*BYTE_W-1:0] shd_flat;
    logic [NUM_REGS*BYTE_W-1:0] live_flat;
    logic                       xfer_q;
    logic                       commit_hit;

    assign commit_hit = wr_en && (wr_addr == COMMIT_ADDR);

    dbr_commit u_commit (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (commit_hit),
        .go_bit (wr_data[0]),
        .pend_q (xfer_q)
    );

    for (genvar i = 0; i < COMMIT_IDX; i++) begin : g_loc
        localparam bit    IS_DIRECT = (i == CFG_ADDR) || (i == SEL_ADDR);
        localparam byte_t RV        = (i == CFG_ADDR) ? CFG_RST : 8'h00;
        logic loc_we;
        assign loc_we = wr_en && (wr_addr == ADDR_W'(i));

        dbr_cell #(
            .DIRECT  (IS_DIRECT),
            .RST_VAL (RV)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (loc_we),
            .wr_data  (wr_data),
            .xfer     (xfer_q),
            .shadow_q (shd_flat[i*BYTE_W +: BYTE_W]),
            .live_q   (live_flat[i*BYTE_W +: BYTE_W])
        );
    end

    assign shd_flat[COMMIT_IDX*BYTE_W +: BYTE_W]  = {7'b0, xfer_q};
    assign live_flat[COMMIT_IDX*BYTE_W +: BYTE_W] = {7'b0, xfer_q};

    dbr_rdmux #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .use_live  (live_flat[SEL_ADDR*BYTE_W]),
        .shd_flat  (shd_flat),
        .live_flat (live_flat),
        .rd_data   (rd_data)
    );

    assign live_regs = live_flat;
endmodule

// File: rtl/dbr_bank_chk.sv
module dbr_bank_chk #(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 563,
    parameter int CFG_ADDR = 0,
    parameter int SEL_ADDR = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [7:0]            wr_data,
    input logic [ADDR_W-1:0]     rd_addr,
    input logic [7:0]            rd_data,
    input logic [NUM_REGS*8-1:0] live_regs,
    input logic [NUM_REGS*8-1:0] shd_flat,
    input logic                  xfer_q
);
    localparam logic [ADDR_W-1:0] COMMIT_ADDR = ADDR_W'(NUM_REGS - 1);
    localparam logic [ADDR_W-1:0] CFG_A       = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] SEL_A       = ADDR_W'(SEL_ADDR);

    // R2
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_q |=> $stable(live_regs[31:8]));

    // R3
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_q && !wr_en) |=> (live_regs[31:8] == $past(shd_flat[31:8])));

    // R4
    no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == COMMIT_ADDR && !wr_data[0]) |=> !xfer_q);

    // R5
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_q && !(wr_en && wr_addr == COMMIT_ADDR)) |=> !xfer_q);

    // R6
    direct_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CFG_A) |=> (live_regs[CFG_ADDR*8 +: 8] == $past(wr_data)));

    // R6
    direct_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_A) |=> (live_regs[SEL_ADDR*8 +: 8] == $past(wr_data)));

    // R9
    oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > COMMIT_ADDR) |=> (rd_data == 8'h00));
endmodule

bind dbr_bank dbr_bank_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .CFG_ADDR (CFG_ADDR),
    .SEL_ADDR (SEL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .live_regs (live_regs),
    .shd_flat  (shd_flat),
    .xfer_q    (xfer_q)
);

// File: tb/dbr_bank_tb.sv
module dbr_bank_tb;
    localparam int ADDR_W   = 10;
    localparam int NUM_REGS = 563;
    localparam logic [ADDR_W-1:0] COMMIT = 10'h232;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic [ADDR_W-1:0]     wr_addr = '0;
    logic [7:0]            wr_data = '0;
    logic [ADDR_W-1:0]     rd_addr = '0;
    logic [7:0]            rd_data;
    logic [NUM_REGS*8-1:0] live_regs;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    dbr_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .live_regs (live_regs)
    );

    function automatic logic [7:0] live_at(int a);
        return live_regs[a*8 +: 8];
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // called on a falling edge, returns on the next falling edge
    task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 live cfg", live_at(0), 8'h18);
        check("R1 live 0x010", live_at(16), 8'h00);
        check("R1 live 0x231", live_at(561), 8'h00);
        rd(10'h000, d); check("R1 shadow cfg", d, 8'h18);
        rd(COMMIT, d);  check("R1 commit reg", d, 8'h00);
    endtask

    task automatic t_shadow_write();
        logic [7:0] d;
        wr(10'h010, 8'hA5);
        wr(10'h231, 8'h3C);
        check("R2 live 0x010 held", live_at(16), 8'h00);
        check("R2 live 0x231 held", live_at(561), 8'h00);
        rd(10'h010, d); check("R2 shadow 0x010", d, 8'hA5);
    endtask

    task automatic t_no_go();
        wr(COMMIT, 8'h00);
        wr(COMMIT, 8'hFE);
        @(negedge clk);
        check("R4 live 0x010 after zero go", live_at(16), 8'h00);
        check("R4 live 0x231 after zero go", live_at(561), 8'h00);
    endtask

    task automatic t_commit();
        logic [7:0] d;
        wr(COMMIT, 8'h01);
        @(negedge clk);
        check("R3 live 0x010", live_at(16), 8'hA5);
        check("R3 live 0x231", live_at(561), 8'h3C);
        rd(COMMIT, d); check("R5 commit reg cleared", d, 8'h00);
    endtask

    task automatic t_direct();
        wr(10'h000, 8'h81);
        check("R6 cfg live at once", live_at(0), 8'h81);
        wr(10'h004, 8'h01);
        check("R6 select live at once", live_at(4), 8'h01);
    endtask

    task automatic t_rdsel();
        logic [7:0] d;
        wr(10'h020, 8'h77);
        rd(10'h020, d); check("R7 live source", d, 8'h00);
        wr(10'h004, 8'h00);
        rd(10'h020, d); check("R7 shadow source", d, 8'h77);
    endtask

    task automatic t_merge();
        wr(COMMIT, 8'h01);
        wr(10'h030, 8'h5A);
        check("R8 merged write live", live_at(48), 8'h5A);
        check("R8 earlier shadow live", live_at(32), 8'h77);
    endtask

    task automatic t_oob();
        logic [7:0] d;
        wr(10'h300, 8'hFF);
        rd(10'h300, d); check("R9 read 0x300", d, 8'h00);
        rd(10'h233, d); check("R9 read 0x233", d, 8'h00);
        rd(10'h004, d); check("R9 select untouched", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow_write();
        t_no_go();
        t_commit();
        t_direct();
        t_rdsel();
        t_merge();
        t_oob();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got 0x00 expected 0x01");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule